// File: doc/BRIEF.md
# Serial ADC Lane Deserializer with Bit-Slip Calibration

This block takes one serial lane from a 12-bit sampling converter, together with the converter's forwarded bit clock and its frame clock, and turns it into parallel samples. Each edge of the bit clock captures one data bit. The captured bits fill two 6-bit shift registers, one for each clock edge. At every rising edge of the frame clock, the two registers are interleaved into a raw 12-bit word, with the first bit to arrive placed in the most significant position. The block assumes the bit clock is already centred in the data eye, so it does no delay-tap scanning.

The frame clock edge does not have to fall on a sample boundary. A calibration sequencer corrects for this while the converter sends its MSB test pattern, in which only the top bit of each word is set. The sequencer waits for a raw word that has exactly one set bit. From the position of that bit it works out a slip amount. It then requires the realigned word to equal the test pattern on several frames in a row before it locks. Once locked, the slip stays fixed. Every later sample is taken from a 12-bit window that slides across the two most recent raw words, so each output is exactly one sample as the converter sent it.

The bit clock drives `clk`, and one frame lasts six bit-clock cycles. Software or a supervisor pulses `cal_start` while the converter is in test-pattern mode. It waits for `cal_done`, and then switches the converter to normal data.

Top module: `adc_lane_deser`

## Requirements
- R1: One serial bit is captured on each edge of `clk`, which gives 12 bits per six-cycle frame. Within a word, the earliest bit received becomes bit 11 of the raw word.
- R2: After a synchronous reset, `cal_done`, `cal_error`, `sample_valid` and `sample_out` are all 0. The block stays idle, and never locks, until `cal_start` is pulsed.
- R3: A one-cycle pulse on `cal_start` restarts calibration from any state. In the following cycle, both `cal_done` and `cal_error` are low.
- R4: Calibration accepts a raw word with exactly one set bit at position p, where bit 11 is the first bit to arrive. It takes a slip of 11 - p, so that the realigned test word reads 12'h800. This works for any offset from 0 to 11 bits between the frame edge and the word boundary.
- R5: Raw words whose count of set bits is not one are skipped. The 64th skipped word raises `cal_error`, returns the sequencer to idle, and leaves `cal_done` low.
- R6: `cal_done` is raised only after 8 consecutive realigned frames equal 12'h800. Any mismatch sends the sequencer back to searching. Because of this rule, `cal_done` cannot appear within 45 cycles of `cal_start`.
- R7: Once locked, each `sample_out` equals one whole transmitted sample. Samples come out in the order they were sent, with none skipped or mixed with a neighbour.
- R8: `sample_valid` pulses for exactly one cycle per frame, which is 25 pulses in any 150 consecutive cycles. It pulses only while `cal_done` is high.
- R9: While locked, the slip does not change whatever data arrives, including words that are not one-hot. `cal_done` stays high and `cal_error` stays low until `cal_start` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock; data is captured on both edges |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial sample data, most significant bit first |
| frame_clk | input | 1 | Frame clock; its rising edge closes a 12-bit word |
| cal_start | input | 1 | One-cycle pulse that starts calibration |
| sample_out | output | 12 | Realigned parallel sample |
| sample_valid | output | 1 | One-cycle strobe per frame once locked |
| cal_done | output | 1 | Calibration has locked a slip value |
| cal_error | output | 1 | 64 words without a single set bit were seen |

## Verification
The properties assume that `frame_clk` is a steady 50 % square wave of six `clk` cycles. They also assume that `sdata` changes only well away from both clock edges, and that `cal_start` is a single-cycle pulse. The bench drives `sdata` and `frame_clk` 1 ns after each edge, from a bit counter that never stops, so the frame period stays exact even across resets. A bit offset chosen per test case shifts the word boundary against the frame edge. Only reset and `cal_start` are toggled asynchronously to the stream, and each of them is held for whole cycles.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

    localparam int SAMPLE_W      = 12;
    localparam int HALF_W        = SAMPLE_W / 2;
    localparam int SLIP_W        = $clog2(SAMPLE_W);
    localparam int VERIFY_FRAMES = 8;
    localparam int MAX_INVALID   = 64;

    typedef logic [SAMPLE_W-1:0] word_t;
    typedef logic [SLIP_W-1:0]   slip_t;

    localparam word_t MSB_PATTERN = word_t'(1) << (SAMPLE_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SEARCH,
        ST_APPLY,
        ST_VERIFY,
        ST_LOCKED
    } cal_state_e;

    // early: bits taken on the falling edge (first of each pair)
    // late : bits taken on the rising edge (second of each pair)
    typedef struct packed {
        logic [HALF_W-1:0] early;
        logic [HALF_W-1:0] late;
    } lane_pair_t;

    // Interleave the two edge streams; oldest pair lands at the top.
    function automatic word_t merge_lanes(input lane_pair_t lp);
        word_t w;
        for (int i = 0; i < HALF_W; i++) begin
            w[2*i+1] = lp.early[i];
            w[2*i]   = lp.late[i];
        end
        return w;
    endfunction

    // Index of the highest set bit (meaningful when exactly one is set).
    function automatic slip_t one_position(input word_t w);
        slip_t p;
        p = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (w[i]) p = slip_t'(i);
        end
        return p;
    endfunction

    // Take SAMPLE_W bits starting 'amt' bits into the {older, newer} stream.
    function automatic word_t window_select(input word_t older, input word_t newer,
                                            input slip_t amt);
        logic [2*SAMPLE_W-1:0] cat;
        word_t w;
        cat = {older, newer};
        for (int i = 0; i < SAMPLE_W; i++) begin
            w[SAMPLE_W-1-i] = cat[2*SAMPLE_W-1-i-int'(amt)];
        end
        return w;
    endfunction

endpackage

// File: rtl/lane_capture.sv
module lane_capture
    import adc_deser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sdata,
    output lane_pair_t lanes
);

    logic fall_q;

    // falling-edge half of the double-data-rate capture
    always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= sdata;
    end

    // rising-edge half, plus the two 6-bit edge shift registers
    always_ff @(posedge clk) begin
        if (rst) begin
            lanes <= '0;
        end else begin
            lanes.early <= {lanes.early[HALF_W-2:0], fall_q};
            lanes.late  <= {lanes.late[HALF_W-2:0],  sdata};
        end
    end

endmodule

// File: rtl/word_assembler.sv
module word_assembler
    import adc_deser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_clk,
    input  lane_pair_t lanes,
    input  slip_t      slip,
    output logic       word_stb,
    output word_t      raw_word,
    output word_t      aligned_word
);

    logic  frame_q;
    word_t prev_word;
    logic  frame_edge;

    assign frame_edge = frame_clk && !frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= 1'b0;
            word_stb  <= 1'b0;
            raw_word  <= '0;
            prev_word <= '0;
        end else begin
            frame_q  <= frame_clk;
            word_stb <= frame_edge;
            if (frame_edge) begin
                raw_word  <= merge_lanes(lanes);
                prev_word <= raw_word;
            end
        end
    end

    assign aligned_word = window_select(prev_word, raw_word, slip);

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import adc_deser_pkg::*;
#(
    parameter int VERIFY_N  = VERIFY_FRAMES,
    parameter int INVALID_N = MAX_INVALID
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cal_start,
    input  logic  word_stb,
    input  word_t raw_word,
    input  word_t aligned_word,
    output slip_t slip,
    output logic  cal_done,
    output logic  cal_error
);

    localparam int VCNT_W = $clog2(VERIFY_N + 1);
    localparam int ICNT_W = $clog2(INVALID_N + 1);

    cal_state_e        state;
    word_t             cand;
    logic [VCNT_W-1:0] vcnt;
    logic [ICNT_W-1:0] icnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cand      <= '0;
            slip      <= '0;
            vcnt      <= '0;
            icnt      <= '0;
            cal_done  <= 1'b0;
            cal_error <= 1'b0;
        end else if (cal_start) begin
            state     <= ST_COLLECT;
            vcnt      <= '0;
            icnt      <= '0;
            cal_done  <= 1'b0;
            cal_error <= 1'b0;
        end else begin
            case (state)
                ST_COLLECT: begin
                    if (word_stb) begin
                        cand  <= raw_word;
                        state <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if ($countones(cand) == 1) begin
                        state <= ST_APPLY;
                    end else if (icnt == ICNT_W'(INVALID_N - 1)) begin
                        icnt      <= icnt + 1'b1;
                        cal_error <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        icnt  <= icnt + 1'b1;
                        state <= ST_COLLECT;
                    end
                end
                ST_APPLY: begin
                    slip  <= slip_t'(SAMPLE_W - 1) - one_position(cand);
                    vcnt  <= '0;
                    state <= ST_VERIFY;
                end
                ST_VERIFY: begin
                    if (word_stb) begin
                        if (aligned_word == MSB_PATTERN) begin
                            if (vcnt == VCNT_W'(VERIFY_N - 1)) begin
                                cal_done <= 1'b1;
                                state    <= ST_LOCKED;
                            end else begin
                                vcnt <= vcnt + 1'b1;
                            end
                        end else begin
                            vcnt  <= '0;
                            state <= ST_COLLECT;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
    import adc_deser_pkg::*;
#(
    parameter int VERIFY_N  = VERIFY_FRAMES,
    parameter int INVALID_N = MAX_INVALID
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sdata,
    input  logic                frame_clk,
    input  logic                cal_start,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic                sample_valid,
    output logic                cal_done,
    output logic                cal_error
);

    lane_pair_t lanes;
    logic       word_stb;
    word_t      raw_word;
    word_t      aligned_word;
    slip_t      slip_q;

    lane_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .sdata (sdata),
        .lanes (lanes)
    );

    word_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .frame_clk    (frame_clk),
        .lanes        (lanes),
        .slip         (slip_q),
        .word_stb     (word_stb),
        .raw_word     (raw_word),
        .aligned_word (aligned_word)
    );

    cal_sequencer #(
        .VERIFY_N  (VERIFY_N),
        .INVALID_N (INVALID_N)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cal_start    (cal_start),
        .word_stb     (word_stb),
        .raw_word     (raw_word),
        .aligned_word (aligned_word),
        .slip         (slip_q),
        .cal_done     (cal_done),
        .cal_error    (cal_error)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= word_stb && cal_done && !cal_start;
            if (word_stb && cal_done && !cal_start) sample_out <= aligned_word;
        end
    end

endmodule

// File: rtl/adc_deser_chk.sv
module adc_deser_chk
    import adc_deser_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cal_start,
    input logic  cal_done,
    input logic  cal_error,
    input logic  sample_valid,
    input slip_t slip
);

    // R8
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> cal_done);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R5
    error_excludes_done_chk: assert property (@(posedge clk) disable iff (rst)
        cal_error |-> !cal_done);

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> (!cal_done && !cal_error));

    // R9
    slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !cal_start) |=> $stable(slip));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !cal_start) |=> cal_done);

    // R4
    slip_range_chk: assert property (@(posedge clk) disable iff (rst)
        slip < slip_t'(SAMPLE_W));

endmodule

bind adc_lane_deser adc_deser_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cal_start    (cal_start),
    .cal_done     (cal_done),
    .cal_error    (cal_error),
    .sample_valid (sample_valid),
    .slip         (slip_q)
);

// File: tb/sim_adc_lane_deser.sv
module sim_adc_lane_deser;
    import adc_deser_pkg::*;

    // {kind[7:6], expect_error[5], unused[4], skew[3:0]}
    // kind 0 = 12'h800 pattern, 1 = all zero, 2 = 12'h801
    localparam logic [7:0] VEC [8] = '{
        8'h00, 8'h01, 8'h05, 8'h06, 8'h0B, 8'h07, 8'h63, 8'hA9
    };

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  sdata = 1'b0;
    logic  frame_clk = 1'b0;
    logic  cal_start = 1'b0;
    word_t sample_out;
    logic  sample_valid, cal_done, cal_error;

    int h = 0;
    int skew = 0;
    int pat_kind = 0;
    int data_from = 1 << 30;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_lane_deser u0 (
        .clk          (clk),
        .rst          (rst),
        .sdata        (sdata),
        .frame_clk    (frame_clk),
        .cal_start    (cal_start),
        .sample_out   (sample_out),
        .sample_valid (sample_valid),
        .cal_done     (cal_done),
        .cal_error    (cal_error)
    );

    function automatic word_t word_at(input int n);
        if (n >= data_from) return word_t'(n) ^ 12'h5A5;
        case (pat_kind)
            1:       return 12'h000;
            2:       return 12'h801;
            default: return 12'h800;
        endcase
    endfunction

    function automatic logic bit_at(input int b);
        word_t w;
        w = word_at(b / SAMPLE_W);
        return w[SAMPLE_W - 1 - (b % SAMPLE_W)];
    endfunction

    // serial stream driver: one bit per half period, frame = 6 cycles
    initial begin
        forever begin
            @(posedge clk); #1;
            sdata     = bit_at(h + skew);
            frame_clk = ((h / 2) % 6) < 3;
            h++;
            @(negedge clk); #1;
            sdata = bit_at(h + skew);
            h++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 cal_start = 1'b1;
        @(posedge clk); #1 cal_start = 1'b0;
    endtask

    // waits for done or error; returns cycles spent
    task automatic wait_outcome(output int cycles);
        cycles = 0;
        while (!cal_done && !cal_error && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    // drive data and check the sample order and strobe rate
    task automatic data_phase(input string tag);
        int  expect_k;
        bit  started;
        bit  ok;
        int  ndata;
        int  nvalid;
        word_t bad_act;
        word_t bad_exp;
        data_from = (h + skew) / SAMPLE_W + 3;
        if ((word_t'(data_from) ^ 12'h5A5) == 12'h800) data_from++;
        expect_k = data_from;
        started = 0;
        ok = 1;
        ndata = 0;
        nvalid = 0;
        bad_act = '0;
        bad_exp = '0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (sample_valid) begin
                nvalid++;
                if (!started && sample_out == 12'h800) begin
                    // still the test pattern
                end else begin
                    started = 1;
                    if (sample_out != (word_t'(expect_k) ^ 12'h5A5)) begin
                        if (ok) begin
                            bad_act = sample_out;
                            bad_exp = word_t'(expect_k) ^ 12'h5A5;
                        end
                        ok = 0;
                    end
                    expect_k++;
                    ndata++;
                end
            end
        end
        chk(ok, {"R1 R7 sample order ", tag}, int'(bad_act), int'(bad_exp));
        chk(ndata >= 20, {"R7 data sample count ", tag}, ndata, 20);
        chk(nvalid == 25, {"R8 strobe count per 150 cycles ", tag}, nvalid, 25);
        chk(cal_done && !cal_error, {"R9 lock held over data ", tag},
            int'({cal_done, cal_error}), 2);
        data_from = 1 << 30;
    endtask

    initial begin
        int cycles;
        int nvalid;
        bit early_done;

        // R2: reset state and idle without a start pulse
        do_reset();
        @(negedge clk);
        chk(!cal_done && !cal_error && !sample_valid && sample_out == '0,
            "R2 reset outputs", int'({cal_done, cal_error, sample_valid}), 0);
        nvalid = 0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (sample_valid || cal_done) nvalid++;
        end
        chk(nvalid == 0, "R2 idle without start", nvalid, 0);

        // table of skews and pattern kinds
        for (int v = 0; v < 8; v++) begin
            pat_kind  = int'(VEC[v][7:6]);
            skew      = int'(VEC[v][3:0]);
            data_from = 1 << 30;
            do_reset();
            pulse_start();
            early_done = 0;
            nvalid = 0;
            for (int c = 0; c < 45; c++) begin
                @(negedge clk);
                if (cal_done) early_done = 1;
                if (sample_valid) nvalid++;
            end
            chk(!early_done, $sformatf("R6 no early lock vec%0d", v), int'(early_done), 0);
            wait_outcome(cycles);
            if (VEC[v][5]) begin
                chk(cal_error && !cal_done, $sformatf("R5 error raised vec%0d", v),
                    int'({cal_error, cal_done}), 2);
                chk(nvalid == 0, $sformatf("R8 no strobe while calibrating vec%0d", v),
                    nvalid, 0);
                pulse_start();
                @(negedge clk);
                chk(!cal_error && !cal_done, $sformatf("R3 start clears error vec%0d", v),
                    int'(cal_error), 0);
            end else begin
                chk(cal_done && !cal_error, $sformatf("R4 lock at skew %0d", skew),
                    int'({cal_done, cal_error}), 2);
                data_phase($sformatf("skew%0d", skew));
            end
        end

        // R3: recalibration from LOCKED after the word boundary moves
        pat_kind = 0;
        skew = 2;
        do_reset();
        pulse_start();
        wait_outcome(cycles);
        chk(cal_done, "R4 lock at skew 2", int'(cal_done), 1);
        skew = 8;
        pulse_start();
        @(negedge clk);
        chk(!cal_done, "R3 start drops done while locked", int'(cal_done), 0);
        wait_outcome(cycles);
        chk(cal_done && !cal_error, "R3 relock at skew 8", int'(cal_done), 1);
        data_phase("relock");

        finish_run();
    end

endmodule